// File: doc/BRIEF.md
# PCIe Receiver Electrical Idle Inference

This block sits on the receive side of a PCIe PHY, after 8b/10b decoding. It decides whether the link partner has gone to electrical idle by looking at the decoded symbol stream, not at the analog squelch detector. The link state machine drives a 3-bit select code. The code picks how the decision is made. In one case the block waits for training ordered sets. In another it counts COM symbols inside a fixed interval. It can also pass through the EIOS detector's pulse. Each interval's length depends on that code and on the current data rate.

The block runs on the symbol clock, one decoded symbol per cycle at most. The clock rate doubles at Gen2, so each interval is expressed in symbol cycles. Intervals are fixed and do not overlap. The decision is made at the end of each interval and held until the next one. A change of select code or rate discards the interval in progress. When the enable strap is low, the block simply inverts the squelch signal-detect level.

Top module: `eidle_infer`

## Requirements
- R1: With `enable` low, `elecIdle` equals the inverse of `sigDet` in the same cycle, and symbols have no effect.
- R2: With `enable` high and `sel[2]` = 0 (codes 000 to 011), `elecIdle` equals `eiosDet` in the same cycle.
- R3: Code 101 uses a window of 128 symbol cycles at both rates. At the window end, `elecIdle` becomes 1 if no complete TS1 or TS2 finished inside the window, and 0 otherwise. COM symbols alone do not count in this mode.
- R4: A training set is recognised only under these rules. It starts with a valid COM (K-flag 1, byte 0xBC), followed by 15 further valid symbols. Symbols 7 to 15 are data (K-flag 0) and are all 0x4A (TS1) or all 0x45 (TS2). Symbols 1 to 6 are not inspected. Cycles with `symValid` low are skipped. On a mismatch the match is abandoned, or restarts if the mismatching symbol is itself a COM. A set that begins with any other K symbol, such as 0xFC, never matches.
- R5: Code 110 uses a window of 200 symbol cycles at Gen1 (`gen2` = 0) and 1600 at Gen2. At the window end, `elecIdle` becomes 1 if fewer than 4 valid COM symbols arrived in the window, and 0 otherwise.
- R6: Code 111 at Gen1 uses the COM rule of R5 over a window of `LOOP_WIN_CYC` cycles. Code 111 at Gen2, and code 100 at either rate, hold `elecIdle` at 0.
- R7: In the timed modes, `elecIdle` changes only in the cycle after the last cycle of a window, and is otherwise held.
- R8: A change of `sel` or `gen2` restarts the window and clears the COM count, the ordered-set flag and the matcher. `elecIdle` is 0 from the next cycle until the first full window completes. A restart takes priority over a window end in the same cycle.
- R9: A symbol sampled in the last cycle of a window counts toward that window. A symbol sampled in the cycle where a restart is detected is discarded.
- R10: During and after reset, in a timed mode, `elecIdle` is 0 until a first full window completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Inference enable strap |
| sel | input | 3 | Inference select code from the link state machine |
| gen2 | input | 1 | Rate flag, 1 = 5 GT/s |
| symData | input | 8 | Decoded symbol byte |
| symK | input | 1 | Symbol is a control (K) code |
| symValid | input | 1 | Symbol qualifier |
| eiosDet | input | 1 | EIOS detection input |
| sigDet | input | 1 | Squelch signal-detect level |
| elecIdle | output | 1 | Electrical idle indication |

## Verification
Two events can land in the same cycle. The last cycle of a window, where the decision is taken, can coincide with the arrival of a COM symbol. It can also coincide with a change of the select code or rate. The bench places a fourth COM exactly on a window's final cycle and expects no idle. It places the next window's first COM one cycle later and expects that COM to be credited only forward. It also changes the rate on the final cycle of a window that would have reported idle, and expects the restart to win, with `elecIdle` low afterwards.

// File: rtl/eidle_infer_pkg.sv
package eidle_infer_pkg;

  typedef enum logic [2:0] {
    MODE_SQUELCH,
    MODE_EIOS,
    MODE_TS,
    MODE_COM,
    MODE_OFF
  } inferMode_e;

  typedef struct packed {
    inferMode_e mode;
    logic       restart;
    logic       winEnd;
  } inferStb_t;

  localparam logic [7:0] SYM_COM = 8'hBC;
  localparam logic [7:0] SYM_TS1_ID = 8'h4A;
  localparam logic [7:0] SYM_TS2_ID = 8'h45;
  localparam int TS_LEN = 16;
  localparam int TS_ID_FIRST = 7;

endpackage

// File: rtl/eidle_infer_ctrl.sv
module eidle_infer_ctrl
  import eidle_infer_pkg::*;
#(
  parameter int TS_WIN_CYC       = 128,
  parameter int COM_WIN_GEN1_CYC = 200,
  parameter int COM_WIN_GEN2_CYC = 1600,
  parameter int LOOP_WIN_CYC     = 32000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [2:0] sel,
  input  logic       gen2,
  output inferStb_t  stb
);

  localparam int MAX_A = (TS_WIN_CYC > COM_WIN_GEN1_CYC) ? TS_WIN_CYC : COM_WIN_GEN1_CYC;
  localparam int MAX_B = (COM_WIN_GEN2_CYC > LOOP_WIN_CYC) ? COM_WIN_GEN2_CYC : LOOP_WIN_CYC;
  localparam int MAX_WIN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW = $clog2(MAX_WIN + 1);

  logic [2:0]    prevSel;
  logic          prevGen2;
  logic [CW-1:0] cnt;
  logic [CW-1:0] winLen;
  inferMode_e    mode;
  logic          timed;
  logic          changed;
  logic          restart;
  logic          winEnd;

  always_comb begin
    mode   = MODE_OFF;
    winLen = CW'(TS_WIN_CYC);
    if (!enable) begin
      mode = MODE_SQUELCH;
    end else if (!sel[2]) begin
      mode = MODE_EIOS;
    end else begin
      case (sel[1:0])
        2'b01: begin
          mode   = MODE_TS;
          winLen = CW'(TS_WIN_CYC);
        end
        2'b10: begin
          mode   = MODE_COM;
          winLen = gen2 ? CW'(COM_WIN_GEN2_CYC) : CW'(COM_WIN_GEN1_CYC);
        end
        2'b11: begin
          if (!gen2) begin
            mode   = MODE_COM;
            winLen = CW'(LOOP_WIN_CYC);
          end
        end
        default: mode = MODE_OFF;
      endcase
    end
  end

  assign timed   = (mode == MODE_TS) || (mode == MODE_COM);
  assign changed = (sel != prevSel) || (gen2 != prevGen2);
  assign restart = changed || !timed;
  assign winEnd  = !restart && (cnt == winLen - CW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSel  <= '0;
      prevGen2 <= 1'b0;
      cnt      <= '0;
    end else begin
      prevSel  <= sel;
      prevGen2 <= gen2;
      if (restart || winEnd) cnt <= '0;
      else                   cnt <= cnt + CW'(1);
    end
  end

  assign stb = '{mode: mode, restart: restart, winEnd: winEnd};

endmodule

// File: rtl/eidle_infer_dp.sv
module eidle_infer_dp
  import eidle_infer_pkg::*;
#(
  parameter int COM_MIN = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  inferStb_t stb,
  input  logic [7:0] symData,
  input  logic      symK,
  input  logic      symValid,
  input  logic      eiosDet,
  input  logic      sigDet,
  output logic      elecIdle
);

  localparam int CCW = $clog2(COM_MIN + 1);
  localparam int IW  = $clog2(TS_LEN);

  logic           isCom;
  logic [CCW-1:0] comCnt;
  logic [CCW-1:0] comSum;
  logic           tsSeen;
  logic           tsHit;
  logic [IW-1:0]  idx;
  logic [IW-1:0]  idxNext;
  logic           tsKind;
  logic           kindNext;
  logic           idMatch;
  logic           idleReg;

  assign isCom = symValid && symK && (symData == SYM_COM);

  always_comb begin
    if (isCom && comCnt != CCW'(COM_MIN)) comSum = comCnt + CCW'(1);
    else                                   comSum = comCnt;
  end

  always_comb begin
    idxNext  = idx;
    kindNext = tsKind;
    tsHit    = 1'b0;
    idMatch  = 1'b0;
    if (symValid) begin
      if (idx == '0) begin
        if (isCom) idxNext = IW'(1);
      end else if (idx < IW'(TS_ID_FIRST)) begin
        idxNext = idx + IW'(1);
      end else begin
        if (idx == IW'(TS_ID_FIRST)) begin
          idMatch  = !symK && (symData == SYM_TS1_ID || symData == SYM_TS2_ID);
          kindNext = (symData == SYM_TS2_ID);
        end else begin
          idMatch = !symK && (symData == (tsKind ? SYM_TS2_ID : SYM_TS1_ID));
        end
        if (!idMatch)                       idxNext = isCom ? IW'(1) : '0;
        else if (idx == IW'(TS_LEN - 1)) begin
          tsHit   = 1'b1;
          idxNext = '0;
        end else                            idxNext = idx + IW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.restart) begin
      comCnt  <= '0;
      tsSeen  <= 1'b0;
      idx     <= '0;
      tsKind  <= 1'b0;
      idleReg <= 1'b0;
    end else begin
      idx    <= idxNext;
      tsKind <= kindNext;
      if (stb.winEnd) begin
        comCnt  <= '0;
        tsSeen  <= 1'b0;
        idleReg <= (stb.mode == MODE_COM) ? (comSum < CCW'(COM_MIN)) : !(tsSeen || tsHit);
      end else begin
        comCnt <= comSum;
        tsSeen <= tsSeen || tsHit;
      end
    end
  end

  always_comb begin
    case (stb.mode)
      MODE_SQUELCH:     elecIdle = !sigDet;
      MODE_EIOS:        elecIdle = eiosDet;
      MODE_TS, MODE_COM: elecIdle = idleReg;
      default:          elecIdle = 1'b0;
    endcase
  end

endmodule

// File: rtl/eidle_infer.sv
module eidle_infer
  import eidle_infer_pkg::*;
#(
  parameter int TS_WIN_CYC       = 128,
  parameter int COM_WIN_GEN1_CYC = 200,
  parameter int COM_WIN_GEN2_CYC = 1600,
  parameter int LOOP_WIN_CYC     = 32000,
  parameter int COM_MIN          = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [2:0] sel,
  input  logic       gen2,
  input  logic [7:0] symData,
  input  logic       symK,
  input  logic       symValid,
  input  logic       eiosDet,
  input  logic       sigDet,
  output logic       elecIdle
);

  inferStb_t stb;
  logic      winEnd;

  assign winEnd = stb.winEnd;

  eidle_infer_ctrl #(
    .TS_WIN_CYC      (TS_WIN_CYC),
    .COM_WIN_GEN1_CYC(COM_WIN_GEN1_CYC),
    .COM_WIN_GEN2_CYC(COM_WIN_GEN2_CYC),
    .LOOP_WIN_CYC    (LOOP_WIN_CYC)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .enable(enable),
    .sel   (sel),
    .gen2  (gen2),
    .stb   (stb)
  );

  eidle_infer_dp #(
    .COM_MIN(COM_MIN)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .symData (symData),
    .symK    (symK),
    .symValid(symValid),
    .eiosDet (eiosDet),
    .sigDet  (sigDet),
    .elecIdle(elecIdle)
  );

endmodule

// File: rtl/eidle_infer_chk.sv
module eidle_infer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic [2:0] sel,
  input logic       gen2,
  input logic       eiosDet,
  input logic       sigDet,
  input logic       winEnd,
  input logic       elecIdle
);

  p_squelch_pass_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (elecIdle == !sigDet));

  p_eios_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !sel[2]) |-> (elecIdle == eiosDet));

  p_undefined_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && (sel == 3'b100 || (sel == 3'b111 && gen2))) |-> !elecIdle);

  p_hold_between_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && sel[2] && $past(enable) && $past(sel[2]) &&
     $past(sel) == sel && $past(gen2) == gen2 &&
     $past(sel, 2) == $past(sel) && $past(gen2, 2) == $past(gen2) &&
     !$past(winEnd)) |-> $stable(elecIdle));

  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && sel[2] && (sel != $past(sel) || gen2 != $past(gen2)))
      |=> (!elecIdle || !(enable && sel[2])));

endmodule

bind eidle_infer eidle_infer_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .sel     (sel),
  .gen2    (gen2),
  .eiosDet (eiosDet),
  .sigDet  (sigDet),
  .winEnd  (winEnd),
  .elecIdle(elecIdle)
);

// File: tb/eidle_infer_test.sv
module eidle_infer_test;

  localparam int LOOP_CYC = 300;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b1;
  logic [2:0] sel = 3'b101;
  logic       gen2 = 1'b0;
  logic [7:0] symData = 8'h00;
  logic       symK = 1'b0;
  logic       symValid = 1'b0;
  logic       eiosDet = 1'b0;
  logic       sigDet = 1'b1;
  logic       elecIdle;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  eidle_infer #(.LOOP_WIN_CYC(LOOP_CYC)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .sel(sel), .gen2(gen2),
    .symData(symData), .symK(symK), .symValid(symValid),
    .eiosDet(eiosDet), .sigDet(sigDet), .elecIdle(elecIdle)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (elecIdle !== exp) begin
      errors++;
      $display("FAIL %s: elecIdle=%0b expected %0b", req, elecIdle, exp);
    end
  endtask

  task automatic step(input logic [7:0] d, input logic k, input logic v);
    symData = d; symK = k; symValid = v;
    @(negedge clk);
  endtask

  task automatic setMode(input logic [2:0] s, input logic g, input bit comIn);
    sel = s; gen2 = g;
    if (comIn) step(8'hBC, 1'b1, 1'b1);
    else       step(8'h00, 1'b0, 1'b0);
  endtask

  task automatic feedCom(input int len, input int nCom, input bit comAtEnd);
    for (int i = 0; i < len; i++) begin
      if ((i % 10 == 5 && i / 10 < nCom) || (comAtEnd && i == len - 1)) step(8'hBC, 1'b1, 1'b1);
      else step(8'h00, 1'b0, 1'b1);
    end
  endtask

  function automatic logic [8:0] tsSym(input int p, input int kind, input bit corrupt);
    if (p == 0) return (kind == 2) ? {1'b1, 8'hFC} : {1'b1, 8'hBC};
    if (p < 7) return {1'b0, 8'(p)};
    if (corrupt && p == 10) return {1'b0, 8'h00};
    return (kind == 1) ? {1'b0, 8'h45} : {1'b0, 8'h4A};
  endfunction

  task automatic feedTs(input int len, input int kind, input bit corrupt, input bit gaps);
    int p = 0;
    for (int i = 0; i < len; i++) begin
      if (i >= 4 && p < 16 && !(gaps && i % 2 == 1)) begin
        logic [8:0] s = tsSym(p, kind, corrupt);
        step(s[7:0], s[8], 1'b1);
        p++;
      end else if (i >= 4 && p < 16) step(8'h00, 1'b0, 1'b0);
      else step(8'h00, 1'b0, 1'b1);
    end
  endtask

  task automatic tReset;
    @(negedge clk);
    check("R10 during reset", 1'b0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    feedCom(60, 0, 0);
    check("R10 before first window end", 1'b0);
  endtask

  task automatic tSquelch;
    enable = 1'b0;
    sigDet = 1'b1; #1; check("R1 sigDet high", 1'b0);
    sigDet = 1'b0; #1; check("R1 sigDet low", 1'b1);
    feedTs(40, 0, 0, 0);
    sigDet = 1'b1; #1; check("R1 symbols ignored", 1'b0);
  endtask

  task automatic tEios;
    enable = 1'b1; sel = 3'b011;
    eiosDet = 1'b1; #1; check("R2 eios high", 1'b1);
    eiosDet = 1'b0; #1; check("R2 eios low", 1'b0);
    sel = 3'b000; eiosDet = 1'b1; #1; check("R2 code 000", 1'b1);
    eiosDet = 1'b0;
    @(negedge clk);
  endtask

  task automatic tComGen1;
    setMode(3'b110, 1'b0, 1'b0);
    feedCom(200, 4, 0); check("R5 gen1 four COM", 1'b0);
    feedCom(200, 3, 0); check("R5 gen1 three COM", 1'b1);
    feedCom(100, 0, 0); check("R7 held mid window", 1'b1);
    feedCom(100, 4, 0); check("R5 gen1 four COM late half", 1'b0);
    feedCom(200, 3, 1); check("R9 COM on last cycle counts", 1'b0);
    feedCom(200, 3, 0); check("R9 three COM before boundary", 1'b1);
    step(8'hBC, 1'b1, 1'b1);
    feedCom(199, 3, 0); check("R9 COM on first cycle counts forward", 1'b0);
  endtask

  task automatic tComGen2;
    feedCom(200, 0, 0); check("R5 gen1 idle before switch", 1'b1);
    setMode(3'b110, 1'b1, 1'b0); check("R8 rate change clears", 1'b0);
    feedCom(200, 3, 0); check("R5 gen2 no end at 200", 1'b0);
    feedCom(1400, 0, 0); check("R5 gen2 three COM", 1'b1);
    feedCom(1600, 4, 0); check("R5 gen2 four COM", 1'b0);
  endtask

  task automatic tTs;
    setMode(3'b101, 1'b0, 1'b0);
    feedTs(128, 0, 0, 0); check("R3 TS1 seen", 1'b0);
    feedCom(128, 4, 0);   check("R3 COM only is idle", 1'b1);
    feedTs(128, 1, 0, 0); check("R3 TS2 seen", 1'b0);
    feedTs(128, 0, 1, 0); check("R4 corrupted TS", 1'b1);
    feedTs(128, 2, 0, 0); check("R4 non-COM start", 1'b1);
    feedTs(128, 1, 0, 1); check("R4 TS with gaps", 1'b0);
    feedCom(128, 0, 0);   check("R3 no TS gen1", 1'b1);
    setMode(3'b101, 1'b1, 1'b0); check("R8 clear on rate change", 1'b0);
    feedCom(127, 0, 0); check("R7 one short of window", 1'b0);
    step(8'h00, 1'b0, 1'b1); check("R3 gen2 window 128", 1'b1);
  endtask

  task automatic tLoop;
    setMode(3'b111, 1'b0, 1'b0);
    feedCom(LOOP_CYC, 4, 0); check("R6 loop four COM", 1'b0);
    feedCom(LOOP_CYC, 2, 0); check("R6 loop two COM", 1'b1);
    setMode(3'b111, 1'b1, 1'b0); check("R6 loop gen2 low", 1'b0);
    feedCom(2 * LOOP_CYC, 0, 0); check("R6 loop gen2 stays low", 1'b0);
    setMode(3'b100, 1'b0, 1'b0);
    feedCom(LOOP_CYC, 0, 0); check("R6 code 100 low", 1'b0);
  endtask

  task automatic tSwitch;
    setMode(3'b110, 1'b0, 1'b0);
    feedCom(200, 0, 0); check("R5 setup idle", 1'b1);
    feedCom(50, 3, 0);
    setMode(3'b110, 1'b1, 1'b0); check("R8 clear after rate toggle", 1'b0);
    setMode(3'b110, 1'b0, 1'b0); check("R8 clear after toggle back", 1'b0);
    feedCom(200, 1, 0); check("R8 old COMs discarded", 1'b1);
    setMode(3'b101, 1'b0, 1'b0);
    setMode(3'b110, 1'b0, 1'b1);
    feedCom(200, 3, 0); check("R9 COM in restart cycle dropped", 1'b1);
    feedCom(199, 0, 0);
    setMode(3'b110, 1'b1, 1'b0); check("R8 restart beats window end", 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: elecIdle=%0b expected run to finish", elecIdle);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tReset();
    tSquelch();
    tEios();
    tComGen1();
    tComGen2();
    tTs();
    tLoop();
    tSwitch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule